// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

The block gathers single-cycle event pulses from a set of internal sources into a bank of sticky status registers, one bit per source. Each status register has its own mask register. A mask bit at 1 hides its source. A mask bit at 0 lets the source reach a per-register summary bit and the single interrupt request. Software reads the status registers through a small register port, and each read clears the bits it returned.

A global control bit chooses how masked events are handled. With the bit low, masked events are dropped and leave no trace in the status registers. With the bit high, masked events are still latched and can be read, but they never reach the summary register or the interrupt pin. The request goes to a pin stage. A configuration field selects the active level and chooses between a driver that always drives and a driver that only pulls to the active level. In the second mode the output enable is released while the request is idle.

Register map (5-bit address, window in bits 4:3, slot in bits 2:0): 0x00+n is status register n (read clears, writes ignored). 0x08+n is mask register n (read/write). 0x10 is the summary register, where bit n is set when register n holds an unmasked set bit (read only). 0x11 is the configuration register: bit 0 shows masked events, bit 1 selects an active-high pin (0 is active low), and bit 2 selects open-drain mode. Reads return data in the cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask register reads 0xFF, every status register and the configuration register read 0x00, and the pin is inactive and driven (irq_oe_o=1, irq_o=1).
- R2: An event pulse on an unmasked source sets its status bit at the next clock edge. The bit stays set until the register is read, and while it is set the request is active.
- R3: A status bit whose mask bit is 1 never activates the interrupt request.
- R4: Bit n of the summary register at 0x10 is 1 exactly when status register n has a set bit whose mask bit is 0.
- R5: With configuration bit 0 clear, an event on a masked source does not change its status bit.
- R6: With configuration bit 0 set, an event on a masked source is latched and readable, and it is absent from the summary register and the pin.
- R7: A read of status register n returns its contents in the following cycle and clears every bit it returned.
- R8: An event arriving in the same cycle as a read of its status register is not lost. It is set after the read, and the read returns the value from before the read.
- R9: Clearing a mask bit whose status bit is already set activates the request, and the change is visible on the pin in the cycle after the write.
- R10: Configuration bit 1 selects the active pin level: 1 means the pin is high when active, 0 means it is low when active.
- R11: With configuration bit 2 set, irq_oe_o is 1 only while the request is active and irq_o holds the active level. With bit 2 clear, irq_oe_o is always 1.
- R12: Mask and configuration registers read back what was written. Writes to status registers have no effect. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_REGS*REG_W | Event pulses; bit n*REG_W+b feeds status register n bit b |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rd_i | input | 1 | Read strobe; status reads clear |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after reg_rd_i |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume that a read strobe addresses one register for one cycle and that event pulses may arrive in any cycle, including the cycle of a read or a mask write. The properties on the status registers are written to allow those overlaps. The stimulus changes inputs only on the falling clock edge, keeps each strobe to a single cycle, and uses only documented addresses, plus one unmapped address for the zero-read check. It deliberately places an event in the same cycle as a read of the same register, so the overlap the assertions allow is also exercised.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // address layout: window selects register kind, slot selects index
   localparam int SLOT_W = 3;

   localparam logic [1:0] WIN_STATUS = 2'd0;
   localparam logic [1:0] WIN_MASK   = 2'd1;
   localparam logic [1:0] WIN_MISC   = 2'd2;

   localparam logic [2:0] SLOT_SUMMARY = 3'd0;
   localparam logic [2:0] SLOT_CONFIG  = 3'd1;

   localparam int CFG_W = 3;

   typedef struct packed {
      logic open_drain;   // bit 2
      logic active_high;  // bit 1
      logic show_masked;  // bit 0
   } irq_cfg_t;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr,
   input  logic         mask_we,
   input  logic [W-1:0] mask_wd,
   input  logic         show_masked,
   output logic [W-1:0] status_q,
   output logic [W-1:0] mask_q,
   output logic         summary
);

   logic [W-1:0] evt_take;
   logic [W-1:0] keep;

   assign evt_take = show_masked ? evt : (evt & ~mask_q);
   assign keep     = clr ? '0 : status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '1;
      end else begin
         status_q <= keep | evt_take;
         if (mask_we) mask_q <= mask_wd;
      end
   end

   assign summary = |(status_q & ~mask_q);

   // R1: masks come out of reset all set
   a_r1_mask_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n)) |-> (mask_q == '1));

   // R2: bits are sticky until a read clears them
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> ((~status_q & $past(status_q)) == '0));

   // R5: hidden mode never records a masked source
   a_r5_hidden_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (!show_masked) |=> ((status_q & ~$past(status_q) & $past(mask_q)) == '0));

   // R7: after a read only fresh events remain
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((status_q & ~$past(evt)) == '0));

   // R9: unmasking a pending bit raises the summary next cycle
   a_r9_unmask_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && !clr && (|(status_q & ~mask_wd))) |=> summary);

endmodule

// File: rtl/irq_regif.sv
module irq_regif
   import irq_agg_pkg::*;
#(
   parameter int N      = 6,
   parameter int W      = 8,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  wr_en,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [N-1:0][W-1:0]   status,
   input  logic [N-1:0][W-1:0]   mask,
   input  logic [N-1:0]          summary,
   output logic [N-1:0]          clr,
   output logic [N-1:0]          mask_we,
   output logic [W-1:0]          mask_wd,
   output irq_cfg_t              cfg_q,
   output logic [DATA_W-1:0]     rd_data
);

   localparam int WIN_W = ADDR_W - SLOT_W;

   logic [WIN_W-1:0]  win;
   logic [SLOT_W-1:0] slot;
   logic              in_status, in_mask, in_misc;
   logic              cfg_we;
   logic [DATA_W-1:0] rd_next;

   assign win  = addr[ADDR_W-1:SLOT_W];
   assign slot = addr[SLOT_W-1:0];

   assign in_status = (win == WIN_W'(WIN_STATUS));
   assign in_mask   = (win == WIN_W'(WIN_MASK));
   assign in_misc   = (win == WIN_W'(WIN_MISC));
   assign cfg_we    = wr_en && in_misc && (slot == SLOT_CONFIG);
   assign mask_wd   = wr_data[W-1:0];

   for (genvar n = 0; n < N; n++) begin : g_strobe
      assign clr[n]     = rd_en && in_status && (slot == SLOT_W'(n));
      assign mask_we[n] = wr_en && in_mask   && (slot == SLOT_W'(n));
   end

   always_comb begin
      rd_next = '0;
      for (int n = 0; n < N; n++) begin
         if (in_status && slot == SLOT_W'(n)) rd_next = DATA_W'(status[n]);
         if (in_mask   && slot == SLOT_W'(n)) rd_next = DATA_W'(mask[n]);
      end
      if (in_misc && slot == SLOT_SUMMARY) rd_next = DATA_W'(summary);
      if (in_misc && slot == SLOT_CONFIG)  rd_next = DATA_W'(cfg_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         rd_data <= '0;
      end else begin
         if (cfg_we) cfg_q <= irq_cfg_t'(wr_data[CFG_W-1:0]);
         if (rd_en)  rd_data <= rd_next;
      end
   end

   // R12: unmapped window reads as zero
   a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !in_status && !in_mask && !in_misc) |=> (rd_data == '0));

   // R7: at most one status register is cleared by a read
   a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr));

endmodule

// File: rtl/irq_pin_stage.sv
module irq_pin_stage #(
   parameter bit OD_CAPABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic active_high,
   input  logic open_drain,
   output logic pin_o,
   output logic pin_oe
);

   logic od_eff;

   if (OD_CAPABLE) begin : g_od
      assign od_eff = open_drain;
   end else begin : g_pp_only
      assign od_eff = 1'b0;
   end

   always_comb begin
      if (od_eff) begin
         pin_oe = req;
         pin_o  = active_high;
      end else begin
         pin_oe = 1'b1;
         pin_o  = active_high ? req : !req;
      end
   end

   // R11: open-drain releases the pin while idle
   a_r11_od_release: assert property (@(posedge clk) disable iff (!rst_n)
      (od_eff && !req) |-> !pin_oe);

   // R11: push-pull always drives
   a_r11_pp_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!od_eff) |-> pin_oe);

   // R10: a driven pin carries the level selected by polarity
   a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe && req) |-> (pin_o == active_high));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NUM_REGS   = 6,
   parameter int REG_W      = 8,
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter bit OD_CAPABLE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_REGS*REG_W-1:0] evt_i,
   input  logic [ADDR_W-1:0]         reg_addr_i,
   input  logic                      reg_wr_i,
   input  logic [DATA_W-1:0]         reg_wdata_i,
   input  logic                      reg_rd_i,
   output logic [DATA_W-1:0]         reg_rdata_o,
   output logic                      irq_o,
   output logic                      irq_oe_o
);

   if (NUM_REGS < 1 || NUM_REGS > (1 << SLOT_W)) begin : g_chk_n
      $error("NUM_REGS must fit the slot field");
   end
   if (ADDR_W < SLOT_W + 2) begin : g_chk_a
      $error("ADDR_W too small for the register map");
   end
   if (DATA_W < REG_W || DATA_W < NUM_REGS || DATA_W < CFG_W) begin : g_chk_d
      $error("DATA_W narrower than a register");
   end

   logic [NUM_REGS-1:0][REG_W-1:0] status;
   logic [NUM_REGS-1:0][REG_W-1:0] mask;
   logic [NUM_REGS-1:0]            summary;
   logic [NUM_REGS-1:0]            clr;
   logic [NUM_REGS-1:0]            mask_we;
   logic [REG_W-1:0]               mask_wd;
   irq_cfg_t                       cfg;
   logic                           req;

   for (genvar n = 0; n < NUM_REGS; n++) begin : g_bank
      irq_status_bank #(.W(REG_W)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt        (evt_i[n*REG_W +: REG_W]),
         .clr        (clr[n]),
         .mask_we    (mask_we[n]),
         .mask_wd    (mask_wd),
         .show_masked(cfg.show_masked),
         .status_q   (status[n]),
         .mask_q     (mask[n]),
         .summary    (summary[n])
      );
   end

   irq_regif #(
      .N(NUM_REGS), .W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regif (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (reg_addr_i),
      .wr_en  (reg_wr_i),
      .wr_data(reg_wdata_i),
      .rd_en  (reg_rd_i),
      .status (status),
      .mask   (mask),
      .summary(summary),
      .clr    (clr),
      .mask_we(mask_we),
      .mask_wd(mask_wd),
      .cfg_q  (cfg),
      .rd_data(reg_rdata_o)
   );

   assign req = |summary;

   irq_pin_stage #(.OD_CAPABLE(OD_CAPABLE)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .active_high(cfg.active_high),
      .open_drain (cfg.open_drain),
      .pin_o      (irq_o),
      .pin_oe     (irq_oe_o)
   );

   // R3: an active request always has an unmasked pending bit behind it
   a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (|(status & ~mask)));

   // R4: every summary bit is backed by its own register
   a_r4_summary_backed: assert property (@(posedge clk) disable iff (!rst_n)
      (summary != '0) |-> ((status & ~mask) != '0));

endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

   localparam int NUM_REGS = 6;
   localparam int REG_W    = 8;
   localparam int ADDR_W   = 5;
   localparam int DATA_W   = 8;

   localparam logic [1:0] OP_WR  = 2'd0;
   localparam logic [1:0] OP_RD  = 2'd1;
   localparam logic [1:0] OP_EV  = 2'd2;
   localparam logic [1:0] OP_PIN = 2'd3;

   typedef struct packed {
      logic [1:0] op;
      logic [4:0] addr;   // register address, or register index for OP_EV
      logic [7:0] data;
      logic [7:0] exp;    // read value, or {oe,o} for OP_PIN
      logic [3:0] req;    // requirement number for messages
   } vec_t;

   localparam int NV = 43;
   localparam vec_t VECS [NV] = '{
      '{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd1 },  // R1 idle pin, active low push-pull
      '{OP_RD,  5'h08, 8'h00, 8'hFF, 4'd1 },  // R1 mask reset
      '{OP_RD,  5'h0D, 8'h00, 8'hFF, 4'd1 },  // R1 last mask reset
      '{OP_RD,  5'h00, 8'h00, 8'h00, 4'd1 },  // R1 status reset
      '{OP_RD,  5'h11, 8'h00, 8'h00, 4'd1 },  // R1 config reset
      '{OP_EV,  5'd0,  8'h05, 8'h00, 4'd5 },
      '{OP_RD,  5'h00, 8'h00, 8'h00, 4'd5 },  // R5 masked dropped
      '{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd3 },  // R3 pin idle
      '{OP_WR,  5'h08, 8'hFA, 8'h00, 4'd12},
      '{OP_RD,  5'h08, 8'h00, 8'hFA, 4'd12},  // R12 mask readback
      '{OP_EV,  5'd0,  8'h0F, 8'h00, 4'd2 },
      '{OP_PIN, 5'h00, 8'h00, 8'h02, 4'd2 },  // R2 active low asserted
      '{OP_PIN, 5'h00, 8'h00, 8'h02, 4'd2 },  // R2 sticky
      '{OP_RD,  5'h10, 8'h00, 8'h01, 4'd4 },  // R4 summary bit 0
      '{OP_RD,  5'h00, 8'h00, 8'h05, 4'd7 },  // R7 only unmasked bits kept
      '{OP_RD,  5'h00, 8'h00, 8'h00, 4'd7 },  // R7 cleared
      '{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd7 },  // R7 pin idle after clear
      '{OP_WR,  5'h11, 8'h01, 8'h00, 4'd6 },
      '{OP_EV,  5'd3,  8'h80, 8'h00, 4'd6 },
      '{OP_RD,  5'h10, 8'h00, 8'h00, 4'd6 },  // R6 hidden from summary
      '{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd6 },  // R6 hidden from pin
      '{OP_RD,  5'h03, 8'h00, 8'h80, 4'd6 },  // R6 recorded
      '{OP_EV,  5'd3,  8'h40, 8'h00, 4'd9 },
      '{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd9 },  // R9 still masked
      '{OP_WR,  5'h0B, 8'hBF, 8'h00, 4'd9 },
      '{OP_PIN, 5'h00, 8'h00, 8'h02, 4'd9 },  // R9 active after unmask
      '{OP_RD,  5'h10, 8'h00, 8'h08, 4'd4 },  // R4 summary bit 3
      '{OP_WR,  5'h11, 8'h03, 8'h00, 4'd10},
      '{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd10},  // R10 active high
      '{OP_WR,  5'h11, 8'h07, 8'h00, 4'd11},
      '{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd11},  // R11 OD driving active
      '{OP_RD,  5'h03, 8'h00, 8'h40, 4'd7 },  // R7
      '{OP_PIN, 5'h00, 8'h00, 8'h01, 4'd11},  // R11 OD released
      '{OP_WR,  5'h11, 8'h05, 8'h00, 4'd11},
      '{OP_PIN, 5'h00, 8'h00, 8'h00, 4'd11},  // R11 OD active low released
      '{OP_WR,  5'h00, 8'hFF, 8'h00, 4'd12},
      '{OP_RD,  5'h00, 8'h00, 8'h00, 4'd12},  // R12 status write ignored
      '{OP_RD,  5'h1F, 8'h00, 8'h00, 4'd12},  // R12 unmapped
      '{OP_RD,  5'h11, 8'h00, 8'h05, 4'd12},  // R12 config readback
      '{OP_WR,  5'h0D, 8'h00, 8'h00, 4'd4 },
      '{OP_EV,  5'd5,  8'h3C, 8'h00, 4'd4 },
      '{OP_RD,  5'h10, 8'h00, 8'h20, 4'd4 },  // R4 summary bit 5
      '{OP_RD,  5'h05, 8'h00, 8'h3C, 4'd2 }   // R2 latched pattern
   };

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic [NUM_REGS*REG_W-1:0] evt = '0;
   logic [ADDR_W-1:0]         addr = '0;
   logic                      wr = 1'b0;
   logic [DATA_W-1:0]         wdata = '0;
   logic                      rd = 1'b0;
   logic [DATA_W-1:0]         rdata;
   logic                      irq, irq_oe;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   irq_aggregator #(
      .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr),
      .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
      .reg_rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input int rq,
                        input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %02h expected %02h", rq, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      @(negedge clk);
      case (v.op)
         OP_WR: begin addr = v.addr; wdata = v.data; wr = 1'b1; end
         OP_RD: begin addr = v.addr; rd = 1'b1; end
         OP_EV: begin evt = '0; evt[int'(v.addr)*REG_W +: REG_W] = v.data; end
         default: ;
      endcase
      @(posedge clk);
      #1;
      wr = 1'b0; rd = 1'b0; evt = '0;
      if (v.op == OP_RD)  check(rdata, v.exp, int'(v.req), "read");
      if (v.op == OP_PIN) check({6'd0, irq_oe, irq}, v.exp, int'(v.req), "pin");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R8: event in the same cycle as a read of its register (reg0 mask FA)
      run_vec('{OP_EV, 5'd0, 8'h04, 8'h00, 4'd8});
      @(negedge clk);
      addr = 5'h00; rd = 1'b1; evt = '0; evt[0] = 1'b1;
      @(posedge clk); #1;
      rd = 1'b0; evt = '0;
      check(rdata, 8'h04, 8, "read with concurrent event");
      run_vec('{OP_RD, 5'h00, 8'h00, 8'h01, 4'd8});   // R8 new event kept

      // R1: reset mid-run restores defaults
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      run_vec('{OP_PIN, 5'h00, 8'h00, 8'h03, 4'd1});   // R1 pin
      run_vec('{OP_RD,  5'h0A, 8'h00, 8'hFF, 4'd1});   // R1 mask
      run_vec('{OP_RD,  5'h11, 8'h00, 8'h00, 4'd1});   // R1 config
      run_vec('{OP_RD,  5'h05, 8'h00, 8'h00, 4'd1});   // R1 status

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule